// File: doc/BRIEF.md
# Offset-Encoded Programmable Clock Divider

This block divides a reference clock by a ratio taken from a 10-bit code. The code is stored with an offset of two, so the smallest code gives divide-by-two and the largest gives divide-by-1025. No code value can request divide-by-zero or divide-by-one. The divided output is driven straight from a flop, so it never glitches.

A new code is presented on `div_code` together with a one-cycle `code_load` strobe. The block keeps the code in a staging register. It moves the code into the active setting only where a new output period starts, which is the rising edge of the output. The period that is running when a load arrives always finishes with its old length. No shortened high or low phase is ever produced. Code, strobe and output are plain control pins: there is no handshake, and the block accepts a load on any cycle.

Top module: `offset_clk_div`

## Requirements
- R1: The output period, counted in reference cycles, equals the active 10-bit code plus two.
- R2: Code 0 gives a period of 2 cycles, code 1 gives 3 cycles, and code 1023 (all ones) gives 1025 cycles.
- R3: While `rst_n` is low the output is low and the active code is 0. The first reference rising edge after release drives the output high, and from then on the block divides by two until a load arrives.
- R4: For an even period N, the output is high for N/2 cycles and low for N/2 cycles.
- R5: For an odd period N, the output is high for (N-1)/2 cycles and low for (N+1)/2 cycles, so the high phase is one cycle shorter.
- R6: A code is captured on the reference edge where `code_load` is high. It governs the first period that begins after that edge. The period in progress keeps its old length.
- R7: If a load is captured on the same edge that ends a period, the loaded code governs the period that begins on that edge.
- R8: If several loads fall inside one period, the last one captured governs the next period.
- R9: The output rises only at the start of a period. A load never changes the high time of the period in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| div_code | input | 10 | Divisor code; the ratio is the code plus two |
| code_load | input | 1 | Strobe that captures `div_code` on this edge |
| clk_out | output | 1 | Divided clock, driven from a flop |

## Verification
Two functions can fall on the same reference edge: capturing a new code, and ending a period (which also swaps the active code). The bench counts reference cycles from each observed rising edge of the output. It places the load strobe in the last cycle of a period, so that the capture and the wrap share one edge. It then checks two things: the period in progress still has the old length, and the period that starts on that edge already has the new length. Random placements of single and back-to-back loads are judged the same way: the old period must keep its length and high time, and the next period must match the code captured last.

// File: rtl/ocd_pkg.sv
package ocd_pkg;
  // Default width of the divisor code field.
  localparam int unsigned CODE_W_DEF = 10;
  // Constant added to the stored code to form the division ratio.
  localparam int unsigned CODE_OFFSET_DEF = 2;

  // Counter width able to hold (largest ratio - 1).
  function automatic int unsigned cnt_width(input int unsigned code_w, input int unsigned offset);
    return $clog2((1 << code_w) + offset);
  endfunction
endpackage

// File: rtl/ocd_code_stage.sv
// Keeps the most recently loaded code and moves it into the active setting
// only on the edge that ends a period. A load on that same edge is forwarded.
module ocd_code_stage #(
  parameter int unsigned CODE_W   = 10,
  parameter int unsigned OFFSET   = 2,
  parameter int unsigned CNT_W    = 11,
  parameter logic [CODE_W-1:0] RESET_CODE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CODE_W-1:0] code_in,
  input  logic              wrap,
  output logic [CODE_W-1:0] active,
  output logic [CNT_W-1:0]  term,
  output logic [CNT_W-1:0]  half
);
  logic [CODE_W-1:0] staged_q;
  logic [CODE_W-1:0] staged_nxt;
  logic [CNT_W-1:0]  ratio;

  assign staged_nxt = load ? code_in : staged_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      staged_q <= RESET_CODE;
      active   <= RESET_CODE;
    end else begin
      staged_q <= staged_nxt;
      if (wrap) begin
        active <= staged_nxt;
      end
    end
  end

  always_comb begin
    ratio = CNT_W'(active) + CNT_W'(OFFSET);
    term  = ratio - CNT_W'(1);
    half  = ratio >> 1;
  end
endmodule

// File: rtl/ocd_count.sv
// Period counter: runs 0..term, then wraps to zero.
module ocd_count #(
  parameter int unsigned CNT_W = 11,
  parameter logic [CNT_W-1:0] RESET_CNT = CNT_W'(1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] term,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             wrap
);
  assign wrap    = (cnt >= term);
  assign cnt_nxt = wrap ? '0 : cnt + CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= RESET_CNT;
    end else begin
      cnt <= cnt_nxt;
    end
  end
endmodule

// File: rtl/ocd_phase.sv
// Registered output: high for counts below the half threshold.
module ocd_phase #(
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrap,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic [CNT_W-1:0] half,
  output logic             out_q
);
  logic out_nxt;

  // At the wrap the new period starts high whatever its ratio (half >= 1).
  assign out_nxt = wrap | (cnt_nxt < half);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= 1'b0;
    end else begin
      out_q <= out_nxt;
    end
  end
endmodule

// File: rtl/offset_clk_div.sv
module offset_clk_div #(
  parameter int unsigned CODE_W = ocd_pkg::CODE_W_DEF,
  parameter int unsigned OFFSET = ocd_pkg::CODE_OFFSET_DEF
) (
  input  logic              clk_ref,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] div_code,
  input  logic              code_load,
  output logic              clk_out
);
  localparam int unsigned CNT_W = ocd_pkg::cnt_width(CODE_W, OFFSET);
  localparam logic [CODE_W-1:0] RESET_CODE = '0;
  // Reset parks the counter on the last count of the reset ratio.
  localparam logic [CNT_W-1:0] RESET_CNT = CNT_W'(OFFSET - 1);

  logic [CODE_W-1:0] active_code;
  logic [CNT_W-1:0]  term;
  logic [CNT_W-1:0]  half;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  cnt_nxt;
  logic              wrap;

  ocd_code_stage #(
    .CODE_W(CODE_W), .OFFSET(OFFSET), .CNT_W(CNT_W), .RESET_CODE(RESET_CODE)
  ) i_stage (
    .clk(clk_ref), .rst_n(rst_n), .load(code_load), .code_in(div_code),
    .wrap(wrap), .active(active_code), .term(term), .half(half)
  );

  ocd_count #(.CNT_W(CNT_W), .RESET_CNT(RESET_CNT)) i_count (
    .clk(clk_ref), .rst_n(rst_n), .term(term),
    .cnt(cnt_q), .cnt_nxt(cnt_nxt), .wrap(wrap)
  );

  ocd_phase #(.CNT_W(CNT_W)) i_phase (
    .clk(clk_ref), .rst_n(rst_n), .wrap(wrap),
    .cnt_nxt(cnt_nxt), .half(half), .out_q(clk_out)
  );
endmodule

// File: rtl/ocd_chk.sv
module ocd_chk #(
  parameter int unsigned CODE_W = 10,
  parameter int unsigned CNT_W  = 11
) (
  input logic              clk_ref,
  input logic              rst_n,
  input logic [CODE_W-1:0] div_code,
  input logic              code_load,
  input logic              clk_out,
  input logic [CNT_W-1:0]  cnt,
  input logic              wrap,
  input logic [CNT_W-1:0]  half,
  input logic [CNT_W-1:0]  term,
  input logic [CODE_W-1:0] active
);
  // R1
  cnt_in_range_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    cnt <= term);

  // R9
  rise_at_start_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(clk_out) |-> (cnt == '0));

  // R4
  fall_at_half_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $fell(clk_out) |-> (cnt == half));

  // R6
  hold_mid_period_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !wrap |=> $stable(active));

  // R7
  forward_on_wrap_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (wrap && code_load) |=> (active == $past(div_code)));

  // R5
  level_matches_count_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    clk_out == (cnt < half));
endmodule

bind offset_clk_div ocd_chk #(.CODE_W(CODE_W), .CNT_W(CNT_W)) i_chk (
  .clk_ref(clk_ref), .rst_n(rst_n), .div_code(div_code), .code_load(code_load),
  .clk_out(clk_out), .cnt(cnt_q), .wrap(wrap), .half(half), .term(term),
  .active(active_code)
);

// File: tb/test_offset_clk_div.sv
`timescale 1ns/1ps
module test_offset_clk_div;
  localparam int WATCHDOG = 200000;

  logic       clk_ref = 1'b0;
  logic       rst_n;
  logic [9:0] div_code;
  logic       code_load;
  logic       clk_out;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  int cur    = 0;

  always #2.5 clk_ref = ~clk_ref;

  offset_clk_div i_offset_clk_div (
    .clk_ref(clk_ref), .rst_n(rst_n), .div_code(div_code),
    .code_load(code_load), .clk_out(clk_out)
  );

  function automatic int ratio_of(input int c);
    return c + 2;
  endfunction

  function automatic int high_of(input int c);
    return (c + 2) / 2;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wait_rise();
    logic prev;
    prev = clk_out;
    forever begin
      @(negedge clk_ref);
      if (clk_out && !prev) break;
      prev = clk_out;
    end
  endtask

  // Called on the sample right after a rise; stops on the next rise.
  task automatic measure(output int per, output int hi);
    logic last;
    per = 0; hi = 1; last = 1'b1;
    forever begin
      @(negedge clk_ref);
      per++;
      if (clk_out && !last) break;
      if (clk_out) hi++;
      last = clk_out;
    end
  endtask

  // Places a load k cycles into a period (k = ratio-1 hits the wrap edge).
  // With two set, a second code follows on the next cycle and must win.
  task automatic run_case(input string new_req, input int code_a, input int code_b,
                          input int k, input bit two);
    int per, hi, per2, hi2, fin, stop_at;
    logic last;
    fin = two ? code_b : code_a;
    stop_at = two ? k + 2 : k + 1;
    wait_rise();
    per = 0; hi = 1; last = 1'b1;
    if (k == 0) begin div_code = 10'(code_a); code_load = 1'b1; end
    forever begin
      @(negedge clk_ref);
      per++;
      if (code_load && per == stop_at) code_load = 1'b0;
      if (two && per == k + 1) div_code = 10'(code_b);
      if (clk_out && !last) break;
      if (clk_out) hi++;
      last = clk_out;
      if (per == k && k > 0) begin div_code = 10'(code_a); code_load = 1'b1; end
    end
    check("R6", "period in progress at load", per, ratio_of(cur));
    check("R9", "high time of period in progress", hi, high_of(cur));
    measure(per2, hi2);
    check(new_req, $sformatf("period for code %0d", fin), per2, ratio_of(fin));
    if (ratio_of(fin) % 2 == 0)
      check("R4", $sformatf("even high time code %0d", fin), hi2, high_of(fin));
    else
      check("R5", $sformatf("odd high time code %0d", fin), hi2, high_of(fin));
    cur = fin;
  endtask

  always @(posedge clk_ref) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int per, hi, k, c;
    bit two;
    void'($urandom(32'h5A17));
    rst_n = 1'b0; code_load = 1'b0; div_code = '0;
    repeat (3) @(negedge clk_ref);
    check("R3", "output during reset", int'(clk_out), 0);
    rst_n = 1'b1;
    @(negedge clk_ref);
    check("R3", "output after first edge", int'(clk_out), 1);
    measure(per, hi);
    check("R3", "reset ratio period", per, 2);
    check("R3", "reset ratio high time", hi, 1);

    // Directed codes; R2 covers the extremes, R1 the middle ones.
    run_case("R2", 1, 0, 0, 1'b0);
    run_case("R1", 2, 0, 1, 1'b0);
    run_case("R1", 511, 0, 2, 1'b0);
    run_case("R2", 1023, 0, 300, 1'b0);
    run_case("R2", 0, 0, ratio_of(cur) - 1, 1'b0);
    // R7: load lands on the wrap edge.
    run_case("R7", 6, 0, ratio_of(cur) - 1, 1'b0);
    run_case("R7", 3, 0, ratio_of(cur) - 1, 1'b0);
    // R8: back-to-back loads, the second one ending on the wrap edge.
    run_case("R8", 700, 4, ratio_of(cur) - 2, 1'b1);
    run_case("R8", 9, 1023, 1, 1'b1);

    for (int i = 0; i < 14; i++) begin
      c = int'($urandom % 1024);
      k = int'($urandom % 32'(ratio_of(cur)));
      two = 1'($urandom % 2);
      if (two && k + 1 > ratio_of(cur) - 1) two = 1'b0;
      if (two)
        run_case("R8", int'($urandom % 1024), c, k, 1'b1);
      else
        run_case("R1", c, 0, k, 1'b0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule